// File: doc/BRIEF.md
# Physical Memory Region Permission Checker

This block decides whether one memory access may proceed, given a table of protection entries. Each entry is described by an 8-bit configuration byte and an address word. The block turns every entry into an inclusive byte range. Three encodings are supported: a range bounded by the neighbouring entry's address, a naturally aligned four-byte word, and a naturally aligned power-of-two block. The block then tests both the first and the last byte of the access against every range. The lowest-numbered entry that touches the access decides the result. An entry that holds only one of the two bytes denies the access at once.

When an entry fully contains the access, the requested read, write and execute rights are compared with the rights that entry allows. Machine mode bypasses the entry's rights unless the entry is locked. When no entry matches, machine mode is granted and every other mode is denied. The decision is computed combinationally from the inputs and captured in one output register. A result therefore appears on the outputs one clock after its inputs were presented. The block is meant to sit beside a load/store or fetch path that already holds the entry table.

Top module: `pmp_match_chk`

## Requirements
- R1: While `rst` is high at a rising edge, `grant`, `hit_vld` and `hit_idx` are all 0 after that edge. Otherwise the outputs after a rising edge reflect the inputs sampled at that edge.
- R2: Configuration bits [4:3] select the range mode: 0 is off, 1 is top-of-range, 2 is a four-byte word, 3 is a power-of-two block. An entry in mode 0 never matches any byte.
- R3: A top-of-range entry i covers bytes from (address word of entry i-1)·4 up to (its own word)·4 − 1. Entry 0 uses 0 as its lower word. If its own word is 0, or not above the lower word, it covers nothing.
- R4: A four-byte entry covers the bytes word·4 to word·4 + 3.
- R5: For a power-of-two entry, let t be the count of consecutive ones at the bottom of the word. The block spans 2^(t+3) bytes, starting at the word with those t bits cleared, times 4. A word of all ones covers the whole byte address space.
- R6: The access spans `acc_addr` to `acc_addr + size − 1`. A size of 0 stands for XLEN/8 bytes, which is 4 at the default XLEN of 32.
- R7: If an entry holds exactly one of the first and last bytes, the access is denied with `hit_vld` = 0 and `hit_idx` = 0. This holds in every privilege mode.
- R8: Entries are examined from index 0 upward. The first entry that holds either byte decides the result, and higher entries have no effect.
- R9: On a full match, `hit_vld` = 1 and `hit_idx` is the entry index, whether access is granted or not. In `acc_req`, bit 0 requests read, bit 1 write and bit 2 execute. Configuration bits 0, 1 and 2 allow read, write and execute. Outside machine mode, `grant` is 1 only if every requested right is allowed.
- R10: Machine mode is `priv` = 3. In machine mode a fully matching entry allows all rights, unless that entry is locked. An entry is locked when its own bit 7 is set, or when the next entry has bit 7 set and is in top-of-range mode. A locked entry restricts machine mode exactly as in R9.
- R11: If no entry holds either byte, including the case where every entry is off, then `hit_vld` = 0 and `hit_idx` = 0. `grant` is 1 in machine mode and 0 in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flat | input | NUM_ENT*8 | Configuration byte of each entry, entry i in bits [8i+7:8i] |
| addr_flat | input | NUM_ENT*XLEN | Address word of each entry (byte address divided by 4), entry i in slice i |
| acc_addr | input | XLEN+2 | Byte address of the first byte of the access |
| acc_size | input | SZW | Access size in bytes, 0 meaning the default width |
| acc_req | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| priv | input | 2 | Current privilege mode, 3 = machine |
| grant | output | 1 | Registered decision: 1 allows the access |
| hit_vld | output | 1 | Registered flag: an entry fully contained the access |
| hit_idx | output | IDXW | Registered index of that entry, 0 when `hit_vld` is 0 |

## Verification
The assertions assume that the inputs stay stable from one rising edge to the next. They compare each registered result with a copy of the inputs captured at the same edge. They also assume that the last byte of an access does not wrap past the top of the byte address space, because a wrapped last byte would make range tests meaningless. The bench changes inputs only at falling edges. Every access it issues, including those near the all-ones region, ends at or below the highest byte address.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam int CFG_LOCK_BIT = 7;
    localparam int CFG_MODE_LO  = 3;
    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    function automatic amode_e cfg_mode(input logic [7:0] cfg);
        return amode_e'(cfg[CFG_MODE_LO +: 2]);
    endfunction

    function automatic perm_t cfg_perm(input logic [7:0] cfg);
        return perm_t'(cfg[2:0]);
    endfunction

    function automatic logic cfg_lock(input logic [7:0] cfg);
        return cfg[CFG_LOCK_BIT];
    endfunction

endpackage

// File: rtl/pmp_range_dec.sv
module pmp_range_dec
    import pmp_chk_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int ABW = XLEN + 2
) (
    input  logic [7:0]      cfg,
    input  logic [XLEN-1:0] this_word,
    input  logic [XLEN-1:0] prev_word,
    output logic [ABW-1:0]  lo,
    output logic [ABW-1:0]  hi,
    output logic            valid
);

    logic [XLEN-1:0] base_word;
    logic [ABW-1:0]  span;
    int              ones;
    logic            stop;

    always_comb begin
        ones = 0;
        stop = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (!stop) begin
                if (this_word[i]) ones = i + 1;
                else              stop = 1'b1;
            end
        end
        for (int i = 0; i < XLEN; i++) begin
            base_word[i] = (i < ones) ? 1'b0 : this_word[i];
        end
        for (int i = 0; i < ABW; i++) begin
            span[i] = (i < ones + 3);
        end
    end

    always_comb begin
        lo    = '0;
        hi    = '0;
        valid = 1'b0;
        unique case (cfg_mode(cfg))
            AM_OFF: begin
                valid = 1'b0;
            end
            AM_TOR: begin
                lo    = {prev_word, 2'b00};
                hi    = {this_word, 2'b00} - ABW'(1);
                valid = (this_word > prev_word);
            end
            AM_NA4: begin
                lo    = {this_word, 2'b00};
                hi    = {this_word, 2'b11};
                valid = 1'b1;
            end
            AM_NAPOT: begin
                lo    = {base_word, 2'b00};
                hi    = {base_word, 2'b00} | span;
                valid = 1'b1;
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDXW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] first_in,
    input  logic [NUM_ENT-1:0] last_in,
    input  logic [NUM_ENT-1:0] locked,
    input  perm_t [NUM_ENT-1:0] perms,
    input  perm_t              req,
    input  logic               is_mach,
    output logic               grant,
    output logic               hit_vld,
    output logic [IDXW-1:0]    hit_idx
);

    perm_t allow;

    always_comb begin
        grant   = is_mach;
        hit_vld = 1'b0;
        hit_idx = '0;
        allow   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (first_in[i] || last_in[i]) begin
                if (first_in[i] ^ last_in[i]) begin
                    grant   = 1'b0;
                    hit_vld = 1'b0;
                    hit_idx = '0;
                end else begin
                    allow   = (is_mach && !locked[i]) ? perm_t'(3'b111) : perms[i];
                    grant   = ((req & ~allow) == '0);
                    hit_vld = 1'b1;
                    hit_idx = IDXW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/pmp_match_chk.sv
module pmp_match_chk
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int XLEN    = 32,
    parameter int SZW     = 4,
    localparam int ABW      = XLEN + 2,
    localparam int IDXW     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int DEF_SIZE = XLEN / 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_ENT*8-1:0]    cfg_flat,
    input  logic [NUM_ENT*XLEN-1:0] addr_flat,
    input  logic [ABW-1:0]          acc_addr,
    input  logic [SZW-1:0]          acc_size,
    input  logic [2:0]              acc_req,
    input  logic [1:0]              priv,
    output logic                    grant,
    output logic                    hit_vld,
    output logic [IDXW-1:0]         hit_idx
);

    logic [ABW-1:0]     last_byte;
    logic [SZW-1:0]     eff_size;
    logic [NUM_ENT-1:0] first_in;
    logic [NUM_ENT-1:0] last_in;
    logic [NUM_ENT-1:0] locked;
    perm_t [NUM_ENT-1:0] perms;

    logic            grant_d;
    logic            hit_vld_d;
    logic [IDXW-1:0] hit_idx_d;

    always_comb begin
        eff_size  = (acc_size == '0) ? SZW'(DEF_SIZE) : acc_size;
        last_byte = acc_addr + ABW'(eff_size) - ABW'(1);
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        logic [7:0]      cfg_i;
        logic [XLEN-1:0] word_i;
        logic [XLEN-1:0] prev_i;
        logic [ABW-1:0]  lo_i;
        logic [ABW-1:0]  hi_i;
        logic            vld_i;

        assign cfg_i  = cfg_flat[i*8 +: 8];
        assign word_i = addr_flat[i*XLEN +: XLEN];

        if (i == 0) begin : g_first
            assign prev_i = '0;
        end else begin : g_rest
            assign prev_i = addr_flat[(i-1)*XLEN +: XLEN];
        end

        if (i == NUM_ENT - 1) begin : g_top_lock
            assign locked[i] = cfg_lock(cfg_i);
        end else begin : g_next_lock
            logic [7:0] cfg_nx;
            assign cfg_nx    = cfg_flat[(i+1)*8 +: 8];
            assign locked[i] = cfg_lock(cfg_i) ||
                               (cfg_lock(cfg_nx) && cfg_mode(cfg_nx) == AM_TOR);
        end

        pmp_range_dec #(.XLEN(XLEN)) dec_i (
            .cfg       (cfg_i),
            .this_word (word_i),
            .prev_word (prev_i),
            .lo        (lo_i),
            .hi        (hi_i),
            .valid     (vld_i)
        );

        assign first_in[i] = vld_i && (acc_addr  >= lo_i) && (acc_addr  <= hi_i);
        assign last_in[i]  = vld_i && (last_byte >= lo_i) && (last_byte <= hi_i);
        assign perms[i]    = cfg_perm(cfg_i);
    end

    pmp_prio_sel #(.NUM_ENT(NUM_ENT)) sel_i (
        .first_in (first_in),
        .last_in  (last_in),
        .locked   (locked),
        .perms    (perms),
        .req      (perm_t'(acc_req)),
        .is_mach  (priv == PRIV_MACHINE),
        .grant    (grant_d),
        .hit_vld  (hit_vld_d),
        .hit_idx  (hit_idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant   <= 1'b0;
            hit_vld <= 1'b0;
            hit_idx <= '0;
        end else begin
            grant   <= grant_d;
            hit_vld <= hit_vld_d;
            hit_idx <= hit_idx_d;
        end
    end

endmodule

// File: rtl/pmp_match_chk_sva.sv
module pmp_match_chk_sva
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDXW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_ENT*8-1:0] cfg_flat,
    input logic [2:0]           acc_req,
    input logic [1:0]           priv,
    input logic                 grant,
    input logic                 hit_vld,
    input logic [IDXW-1:0]      hit_idx
);

    logic [NUM_ENT*8-1:0] cfg_d;
    logic [2:0]           req_d;
    logic [1:0]           priv_d;
    logic                 armed;
    logic [7:0]           hit_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            cfg_d  <= '0;
            req_d  <= '0;
            priv_d <= '0;
        end else begin
            armed  <= 1'b1;
            cfg_d  <= cfg_flat;
            req_d  <= acc_req;
            priv_d <= priv;
        end
    end

    always_comb hit_cfg = cfg_d[8*int'(hit_idx) +: 8];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!grant && !hit_vld && hit_idx == '0));

    a_r2_off_never_hits: assert property (@(posedge clk) disable iff (rst)
        (armed && hit_vld) |-> (cfg_mode(hit_cfg) != AM_OFF));

    a_r9_user_rights_subset: assert property (@(posedge clk) disable iff (rst)
        (armed && hit_vld && grant && priv_d != PRIV_MACHINE)
            |-> ((req_d & ~hit_cfg[2:0]) == 3'b000));

    a_r10_own_lock_binds_machine: assert property (@(posedge clk) disable iff (rst)
        (armed && hit_vld && grant && hit_cfg[CFG_LOCK_BIT])
            |-> ((req_d & ~hit_cfg[2:0]) == 3'b000));

    a_r11_user_needs_hit: assert property (@(posedge clk) disable iff (rst)
        (armed && !hit_vld && priv_d != PRIV_MACHINE) |-> !grant);

    a_r7_idx_zero_without_hit: assert property (@(posedge clk) disable iff (rst)
        (armed && !hit_vld) |-> (hit_idx == '0));

endmodule

bind pmp_match_chk pmp_match_chk_sva #(.NUM_ENT(NUM_ENT)) sva_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_flat (cfg_flat),
    .acc_req  (acc_req),
    .priv     (priv),
    .grant    (grant),
    .hit_vld  (hit_vld),
    .hit_idx  (hit_idx)
);

// File: tb/pmp_match_chk_tb.sv
module pmp_match_chk_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NE   = 8;
    localparam int XL   = 32;
    localparam int AB   = XL + 2;
    localparam int SW   = 4;
    localparam int IW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0]    cfg_a [NE];
    logic [XL-1:0] adr_a [NE];
    logic [NE*8-1:0]  cfg_flat;
    logic [NE*XL-1:0] addr_flat;
    logic [AB-1:0] acc_addr = '0;
    logic [SW-1:0] acc_size = '0;
    logic [2:0]    acc_req  = '0;
    logic [1:0]    priv     = '0;
    logic          grant;
    logic          hit_vld;
    logic [IW-1:0] hit_idx;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            cfg_flat[i*8 +: 8]   = cfg_a[i];
            addr_flat[i*XL +: XL] = adr_a[i];
        end
    end

    pmp_match_chk #(.NUM_ENT(NE), .XLEN(XL), .SZW(SW)) dut_i (
        .clk(clk), .rst(rst), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_req(acc_req), .priv(priv),
        .grant(grant), .hit_vld(hit_vld), .hit_idx(hit_idx)
    );

    task automatic clear_tab();
        for (int i = 0; i < NE; i++) begin
            cfg_a[i] = 8'h00;
            adr_a[i] = '0;
        end
    endtask

    task automatic check(string req, logic g, logic v, logic [IW-1:0] x);
        tests++;
        if (grant !== g || hit_vld !== v || hit_idx !== x) begin
            fails++;
            $display("FAIL %s: actual grant=%0b vld=%0b idx=%0d, expected grant=%0b vld=%0b idx=%0d",
                     req, grant, hit_vld, hit_idx, g, v, x);
        end
    endtask

    task automatic probe(string req, logic [AB-1:0] a, logic [SW-1:0] s, logic [2:0] r,
                         logic [1:0] p, logic g, logic v, logic [IW-1:0] x);
        @(negedge clk);
        acc_addr = a; acc_size = s; acc_req = r; priv = p;
        @(posedge clk);
        @(negedge clk);
        check(req, g, v, x);
    endtask

    task automatic t_reset();
        clear_tab();
        rst = 1'b1; priv = 2'd3; acc_req = 3'b001; acc_size = 4'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 1'b0, 1'b0, 3'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 first result after reset", 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_no_rules();
        clear_tab();
        probe("R11 no rules machine", 34'h1234, 4'd4, 3'b111, 2'd3, 1, 0, 0);
        probe("R11 no rules user",    34'h1234, 4'd4, 3'b001, 2'd1, 0, 0, 0);
    endtask

    task automatic t_na4();
        clear_tab();
        cfg_a[0] = 8'h11; adr_a[0] = 32'h100;
        probe("R4 word read",        34'h400, 4'd4, 3'b001, 2'd0, 1, 1, 0);
        probe("R9 word write denied", 34'h400, 4'd4, 3'b010, 2'd0, 0, 1, 0);
        probe("R7 partial user",     34'h402, 4'd4, 3'b001, 2'd0, 0, 0, 0);
        probe("R7 partial machine",  34'h402, 4'd4, 3'b001, 2'd3, 0, 0, 0);
        probe("R11 miss machine",    34'h404, 4'd4, 3'b001, 2'd3, 1, 0, 0);
        probe("R11 miss user",       34'h404, 4'd4, 3'b001, 2'd0, 0, 0, 0);
    endtask

    task automatic t_tor();
        clear_tab();
        adr_a[0] = 32'h100;
        cfg_a[1] = 8'h0B; adr_a[1] = 32'h200;
        probe("R3 inside",             34'h500, 4'd4, 3'b001, 2'd0, 1, 1, 1);
        probe("R2 off entry skipped",  34'h400, 4'd4, 3'b001, 2'd0, 1, 1, 1);
        probe("R3 top edge",           34'h7FC, 4'd4, 3'b010, 2'd0, 1, 1, 1);
        probe("R7 crosses top",        34'h7FE, 4'd4, 3'b001, 2'd0, 0, 0, 0);
        probe("R9 exec denied",        34'h500, 4'd4, 3'b100, 2'd0, 0, 1, 1);
        probe("R3 below base",         34'h3FC, 4'd4, 3'b001, 2'd0, 0, 0, 0);
        clear_tab();
        cfg_a[0] = 8'h09; adr_a[0] = 32'h40;
        probe("R3 entry0 from zero",   34'h10, 4'd4, 3'b001, 2'd1, 1, 1, 0);
        probe("R3 entry0 top",         34'hFC, 4'd4, 3'b001, 2'd1, 1, 1, 0);
        clear_tab();
        cfg_a[0] = 8'h0F;
        probe("R3 empty range machine", 34'h0, 4'd4, 3'b001, 2'd3, 1, 0, 0);
        probe("R3 empty range user",    34'h0, 4'd4, 3'b001, 2'd0, 0, 0, 0);
    endtask

    task automatic t_napot();
        clear_tab();
        cfg_a[2] = 8'h1C; adr_a[2] = 32'h41F;
        probe("R5 block top",      34'h10FC, 4'd4, 3'b100, 2'd0, 1, 1, 2);
        probe("R5 block base",     34'h1000, 4'd4, 3'b100, 2'd0, 1, 1, 2);
        probe("R5 past block",     34'h1100, 4'd4, 3'b100, 2'd0, 0, 0, 0);
        probe("R7 block straddle", 34'h10FE, 4'd4, 3'b100, 2'd0, 0, 0, 0);
        probe("R9 block no read",  34'h1000, 4'd4, 3'b001, 2'd0, 0, 1, 2);
        cfg_a[0] = 8'h19; adr_a[0] = 32'hFFFF_FFFF;
        probe("R5 all ones mid",   34'h2_0000_0000, 4'd4, 3'b001, 2'd0, 1, 1, 0);
        probe("R5 all ones top",   34'h3_FFFF_FFFC, 4'd4, 3'b001, 2'd0, 1, 1, 0);
    endtask

    task automatic t_priority();
        clear_tab();
        cfg_a[0] = 8'h10; adr_a[0] = 32'h100;
        cfg_a[1] = 8'h1F; adr_a[1] = 32'h10F;
        probe("R8 lower entry wins",  34'h400, 4'd4, 3'b001, 2'd0, 0, 1, 0);
        probe("R8 falls to entry1",   34'h404, 4'd4, 3'b001, 2'd0, 1, 1, 1);
        probe("R8 lower partial wins", 34'h402, 4'd4, 3'b001, 2'd0, 0, 0, 0);
    endtask

    task automatic t_machine();
        clear_tab();
        cfg_a[0] = 8'h10; adr_a[0] = 32'h100;
        probe("R10 machine unlocked",  34'h400, 4'd4, 3'b111, 2'd3, 1, 1, 0);
        cfg_a[0] = 8'h90;
        probe("R10 machine own lock",  34'h400, 4'd4, 3'b010, 2'd3, 0, 1, 0);
        cfg_a[0] = 8'h91;
        probe("R10 locked read ok",    34'h400, 4'd4, 3'b001, 2'd3, 1, 1, 0);
        cfg_a[0] = 8'h10;
        cfg_a[1] = 8'h88; adr_a[1] = 32'h200;
        probe("R10 next tor lock",     34'h400, 4'd4, 3'b010, 2'd3, 0, 1, 0);
        probe("R10 locked tor itself", 34'h500, 4'd4, 3'b001, 2'd3, 0, 1, 1);
        cfg_a[1] = 8'h90;
        probe("R10 next lock not tor", 34'h400, 4'd4, 3'b010, 2'd3, 1, 1, 0);
    endtask

    task automatic t_size();
        clear_tab();
        cfg_a[0] = 8'h11; adr_a[0] = 32'h100;
        probe("R6 size0 fits",     34'h400, 4'd0, 3'b001, 2'd0, 1, 1, 0);
        probe("R6 size0 straddle", 34'h401, 4'd0, 3'b001, 2'd0, 0, 0, 0);
        probe("R6 size1",          34'h401, 4'd1, 3'b001, 2'd0, 1, 1, 0);
        probe("R6 size1 last",     34'h403, 4'd1, 3'b001, 2'd0, 1, 1, 0);
        probe("R6 size2",          34'h402, 4'd2, 3'b001, 2'd0, 1, 1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_no_rules();
        t_na4();
        t_tor();
        t_napot();
        t_priority();
        t_machine();
        t_size();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual still running, expected finished");
        finish_run();
    end

endmodule